// File: doc/BRIEF.md
# Motion Interrupt Latch and Router

This block turns per-axis motion events into two sticky interrupt flags and two interrupt pins. Level detection happens inside the block. Each axis sample is compared against a shared threshold, either on its magnitude or as a signed value. The per-axis results are combined across the enabled axes, using OR for positive polarity and AND for negative polarity. Pulse qualification is done upstream. The block receives per-axis single-pulse and double-pulse strobes, plus a flag that tells whether the second pulse window is zero. It combines these strobes with the same polarity-dependent OR/AND rule, under a polarity bit of its own.

A 2-bit route mode picks which detector feeds each latch. A swap bit exchanges the two pins. Per-axis source flags record which axes caused the latched events. Two clear strobes, each one clock long, reset the latches and their flag groups. In the single/double route, only the second clear strobe acts, and it resets everything.

Top module: `motion_irq_router`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) drives both latches, both pins and all source flags to 0 by the next sample point.
- R2: With `modeSel`=00, a level event sets `int1Bit` and ORs its contributing axes into `levelSrc`. A single-pulse event sets `int2Bit` and ORs its contributing axes into `pulseSrc`.
- R3: With `modeSel`=01, the routing of R2 is exchanged: a single-pulse event sets `int1Bit` and a level event sets `int2Bit`. The flags go to the same groups as in R2.
- R4: With `modeSel`=10, a single-pulse event sets `int1Bit`. `int2Bit` is set by a single-pulse event when `win2Zero`=1. When `win2Zero`=0, only a double-pulse event sets `int2Bit`.
- R5: With `modeSel`=11, no event sets any latch or flag.
- R6: With `pinSwap`=0, `int1Pin` follows `int1Bit` and `int2Pin` follows `int2Bit`. With `pinSwap`=1, the two are exchanged.
- R7: In modes 00 and 01, `clrInt1` clears `int1Bit` and the flag group routed to it, and `clrInt2` does the same for `int2Bit`. A clear input at 0 has no effect. When a clear and a setting event fall in the same cycle, the event wins.
- R8: With `modeSel`=10, `clrInt1` has no effect. `clrInt2` clears both latches and `pulseSrc`.
- R9: With `levelNeg`=0, an axis hits when its compared value is greater than or equal to the threshold, and any enabled hitting axis fires the level event. With `levelNeg`=1, an axis hits when its value is below the threshold, and the event fires only when every enabled axis hits.
- R10: With `pulseNeg`=0, any enabled axis strobe fires a pulse event. With `pulseNeg`=1, all enabled axes must strobe in the same cycle. The same rule applies to single and double strobes.
- R11: An axis whose `axisDisable` bit is 1 takes no part in level or pulse events, and its source flags are never set. If no axis is enabled, no event fires.
- R12: With `thrSigned`=0, the magnitude of the two's-complement sample (so -128 counts as 128) is compared against `threshold` read as unsigned. With `thrSigned`=1, the sample and `threshold` are compared as signed values.
- R13: Source flags are set only for axes that contributed to a routed event. They stay set until a clear that applies to their group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| modeSel | input | 2 | Route mode: 00, 01, 10, 11 |
| pinSwap | input | 1 | Exchange the two pins |
| axisDisable | input | NUM_AXES | Per-axis exclusion, bit 0 = X |
| thrSigned | input | 1 | Signed threshold compare |
| levelNeg | input | 1 | Level polarity / AND combine |
| pulseNeg | input | 1 | Pulse polarity / AND combine |
| clrInt1 | input | 1 | One-cycle clear strobe, latch 1 |
| clrInt2 | input | 1 | One-cycle clear strobe, latch 2 |
| samples | input | NUM_AXES*SAMPLE_W | Packed signed samples, axis 0 in the low bits |
| threshold | input | SAMPLE_W | Level threshold |
| singlePulse | input | NUM_AXES | Per-axis single-pulse strobes |
| doublePulse | input | NUM_AXES | Per-axis double-pulse strobes |
| win2Zero | input | 1 | Second pulse window is zero |
| int1Bit | output | 1 | Latched interrupt 1 |
| int2Bit | output | 1 | Latched interrupt 2 |
| int1Pin | output | 1 | Interrupt pin 1 |
| int2Pin | output | 1 | Interrupt pin 2 |
| levelSrc | output | NUM_AXES | Per-axis level source flags |
| pulseSrc | output | NUM_AXES | Per-axis pulse source flags |

## Verification
Two functions can fall in the same cycle: a clear strobe for a latch and a new event routed to that same latch. In the single/double mode, a second pair can also coincide: a `clrInt2` and a single pulse that sets both latches. The stimulus provokes both cases directly, by holding a sample over the threshold or raising a strobe in the exact cycle of the clear. Long random runs then mix clears, strobes and mode changes at high rates. A behavioural model compares every cycle and expects the event to win and the flags to be re-seeded with only the new axes.

// File: rtl/motion_irq_pkg.sv
package motion_irq_pkg;

  typedef enum logic [1:0] {
    ROUTE_LVL_PLS = 2'b00,
    ROUTE_PLS_LVL = 2'b01,
    ROUTE_SGL_DBL = 2'b10,
    ROUTE_NONE    = 2'b11
  } routeMode_e;

  typedef struct packed {
    logic set1;
    logic set2;
    logic clr1;
    logic clr2;
    logic setLvlFlags;
    logic setSglFlags;
    logic setDblFlags;
    logic clrLvlFlags;
    logic clrPlsFlags;
  } latchCmd_t;

endpackage

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import motion_irq_pkg::*;
(
  input  logic [1:0] modeSel,
  input  logic       clrInt1,
  input  logic       clrInt2,
  input  logic       win2Zero,
  input  logic       levelEvt,
  input  logic       singleEvt,
  input  logic       doubleEvt,
  output latchCmd_t  cmd
);

  routeMode_e route;
  assign route = routeMode_e'(modeSel);

  always_comb begin
    cmd = '0;
    unique case (route)
      ROUTE_LVL_PLS: begin
        cmd.set1        = levelEvt;
        cmd.set2        = singleEvt;
        cmd.clr1        = clrInt1;
        cmd.clr2        = clrInt2;
        cmd.setLvlFlags = levelEvt;
        cmd.setSglFlags = singleEvt;
        cmd.clrLvlFlags = clrInt1;
        cmd.clrPlsFlags = clrInt2;
      end
      ROUTE_PLS_LVL: begin
        cmd.set1        = singleEvt;
        cmd.set2        = levelEvt;
        cmd.clr1        = clrInt1;
        cmd.clr2        = clrInt2;
        cmd.setLvlFlags = levelEvt;
        cmd.setSglFlags = singleEvt;
        cmd.clrLvlFlags = clrInt2;
        cmd.clrPlsFlags = clrInt1;
      end
      ROUTE_SGL_DBL: begin
        // only the second clear acts, and it resets both latches
        cmd.set1        = singleEvt;
        cmd.set2        = win2Zero ? singleEvt : doubleEvt;
        cmd.clr1        = clrInt2;
        cmd.clr2        = clrInt2;
        cmd.setSglFlags = singleEvt;
        cmd.setDblFlags = doubleEvt && !win2Zero;
        cmd.clrPlsFlags = clrInt2;
      end
      default: begin
        cmd.clr1 = clrInt1;
        cmd.clr2 = clrInt2;
      end
    endcase
  end

endmodule

// File: rtl/irq_latch_dp.sv
module irq_latch_dp
  import motion_irq_pkg::*;
#(
  parameter int NUM_AXES = 3,
  parameter int SAMPLE_W = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_AXES*SAMPLE_W-1:0] samples,
  input  logic [SAMPLE_W-1:0]          threshold,
  input  logic [NUM_AXES-1:0]          axisDisable,
  input  logic                         thrSigned,
  input  logic                         levelNeg,
  input  logic                         pulseNeg,
  input  logic [NUM_AXES-1:0]          singlePulse,
  input  logic [NUM_AXES-1:0]          doublePulse,
  input  latchCmd_t                    cmd,
  output logic                         levelEvt,
  output logic                         singleEvt,
  output logic                         doubleEvt,
  output logic                         int1Bit,
  output logic                         int2Bit,
  output logic [NUM_AXES-1:0]          levelSrc,
  output logic [NUM_AXES-1:0]          pulseSrc
);

  localparam int MAG_W = SAMPLE_W + 1;

  logic [NUM_AXES-1:0] axisEnabled;
  logic [NUM_AXES-1:0] levelHit;
  logic [NUM_AXES-1:0] levelContrib;
  logic [NUM_AXES-1:0] singleContrib;
  logic [NUM_AXES-1:0] doubleContrib;

  assign axisEnabled = ~axisDisable;

  for (genvar ax = 0; ax < NUM_AXES; ax++) begin : g_axis
    logic signed [SAMPLE_W-1:0] smp;
    logic [MAG_W-1:0]           ext;
    logic [MAG_W-1:0]           mag;
    logic                       absMeets;
    logic                       sgnMeets;
    assign smp      = samples[ax*SAMPLE_W +: SAMPLE_W];
    assign ext      = {smp[SAMPLE_W-1], smp};
    assign mag      = smp[SAMPLE_W-1] ? (~ext + MAG_W'(1)) : ext;
    assign absMeets = mag >= {1'b0, threshold};
    assign sgnMeets = smp >= $signed(threshold);
    assign levelHit[ax] = (thrSigned ? sgnMeets : absMeets) ^ levelNeg;
  end

  assign levelContrib  = levelHit    & axisEnabled;
  assign singleContrib = singlePulse & axisEnabled;
  assign doubleContrib = doublePulse & axisEnabled;

  // OR across axes when positive, AND across enabled axes when negative
  function automatic logic combineAxes(input logic [NUM_AXES-1:0] contrib,
                                       input logic [NUM_AXES-1:0] enabled,
                                       input logic                useAnd);
    return useAnd ? ((|enabled) && (contrib == enabled)) : (|contrib);
  endfunction

  assign levelEvt  = combineAxes(levelContrib,  axisEnabled, levelNeg);
  assign singleEvt = combineAxes(singleContrib, axisEnabled, pulseNeg);
  assign doubleEvt = combineAxes(doubleContrib, axisEnabled, pulseNeg);

  always_ff @(posedge clk) begin
    if (rst) begin
      int1Bit  <= 1'b0;
      int2Bit  <= 1'b0;
      levelSrc <= '0;
      pulseSrc <= '0;
    end else begin
      int1Bit  <= (int1Bit & ~cmd.clr1) | cmd.set1;
      int2Bit  <= (int2Bit & ~cmd.clr2) | cmd.set2;
      levelSrc <= (levelSrc & ~{NUM_AXES{cmd.clrLvlFlags}})
                | (cmd.setLvlFlags ? levelContrib : '0);
      pulseSrc <= (pulseSrc & ~{NUM_AXES{cmd.clrPlsFlags}})
                | (cmd.setSglFlags ? singleContrib : '0)
                | (cmd.setDblFlags ? doubleContrib : '0);
    end
  end

endmodule

// File: rtl/motion_irq_router.sv
module motion_irq_router
  import motion_irq_pkg::*;
#(
  parameter int NUM_AXES = 3,
  parameter int SAMPLE_W = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [1:0]                   modeSel,
  input  logic                         pinSwap,
  input  logic [NUM_AXES-1:0]          axisDisable,
  input  logic                         thrSigned,
  input  logic                         levelNeg,
  input  logic                         pulseNeg,
  input  logic                         clrInt1,
  input  logic                         clrInt2,
  input  logic [NUM_AXES*SAMPLE_W-1:0] samples,
  input  logic [SAMPLE_W-1:0]          threshold,
  input  logic [NUM_AXES-1:0]          singlePulse,
  input  logic [NUM_AXES-1:0]          doublePulse,
  input  logic                         win2Zero,
  output logic                         int1Bit,
  output logic                         int2Bit,
  output logic                         int1Pin,
  output logic                         int2Pin,
  output logic [NUM_AXES-1:0]          levelSrc,
  output logic [NUM_AXES-1:0]          pulseSrc
);

  latchCmd_t cmd;
  logic      levelEvt;
  logic      singleEvt;
  logic      doubleEvt;

  irq_route_ctrl u_ctrl (
    .modeSel   (modeSel),
    .clrInt1   (clrInt1),
    .clrInt2   (clrInt2),
    .win2Zero  (win2Zero),
    .levelEvt  (levelEvt),
    .singleEvt (singleEvt),
    .doubleEvt (doubleEvt),
    .cmd       (cmd)
  );

  irq_latch_dp #(.NUM_AXES(NUM_AXES), .SAMPLE_W(SAMPLE_W)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .samples     (samples),
    .threshold   (threshold),
    .axisDisable (axisDisable),
    .thrSigned   (thrSigned),
    .levelNeg    (levelNeg),
    .pulseNeg    (pulseNeg),
    .singlePulse (singlePulse),
    .doublePulse (doublePulse),
    .cmd         (cmd),
    .levelEvt    (levelEvt),
    .singleEvt   (singleEvt),
    .doubleEvt   (doubleEvt),
    .int1Bit     (int1Bit),
    .int2Bit     (int2Bit),
    .levelSrc    (levelSrc),
    .pulseSrc    (pulseSrc)
  );

  assign int1Pin = pinSwap ? int2Bit : int1Bit;
  assign int2Pin = pinSwap ? int1Bit : int2Bit;

endmodule

// File: rtl/irq_router_checker.sv
module irq_router_checker #(
  parameter int NUM_AXES = 3
) (
  input logic                clk,
  input logic                rst,
  input logic [1:0]          modeSel,
  input logic                clrInt1,
  input logic                clrInt2,
  input logic                win2Zero,
  input logic [NUM_AXES-1:0] axisDisable,
  input logic [NUM_AXES-1:0] doublePulse,
  input logic                int1Bit,
  input logic                int2Bit,
  input logic                int1Pin,
  input logic                int2Pin,
  input logic [NUM_AXES-1:0] levelSrc,
  input logic [NUM_AXES-1:0] pulseSrc
);

  assert_reset_clears_R1: assert property (@(posedge clk)
    $past(rst) |-> (!int1Bit && !int2Bit && !int1Pin && !int2Pin &&
                    levelSrc == '0 && pulseSrc == '0));

  assert_pins_carry_bits_R6: assert property (@(posedge clk) disable iff (rst)
    $countones({int1Pin, int2Pin}) == $countones({int1Bit, int2Bit}));

  assert_idle_mode_no_set_R5: assert property (@(posedge clk) disable iff (rst)
    (modeSel == 2'b11 && !int1Bit && !int2Bit) |=> (!int1Bit && !int2Bit));

  assert_int1_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (int1Bit && !clrInt1 && !clrInt2) |=> int1Bit);

  assert_int2_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (int2Bit && !clrInt2) |=> int2Bit);

  assert_clr1_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (modeSel == 2'b10 && int1Bit && !clrInt2) |=> int1Bit);

  assert_double_only_R4: assert property (@(posedge clk) disable iff (rst)
    (modeSel == 2'b10 && !win2Zero && doublePulse == '0 && !int2Bit) |=> !int2Bit);

  assert_all_disabled_R11: assert property (@(posedge clk) disable iff (rst)
    (modeSel == 2'b00 && axisDisable == '1 && !int1Bit && !int2Bit)
      |=> (!int1Bit && !int2Bit));

endmodule

bind motion_irq_router irq_router_checker #(.NUM_AXES(NUM_AXES)) u_chk (.*);

// File: tb/tb_motion_irq_router.sv
`timescale 1ns/1ps
module tb_motion_irq_router;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  modeSel = 2'b00;
  logic        pinSwap = 1'b0;
  logic [2:0]  axisDisable = 3'b000;
  logic        thrSigned = 1'b0;
  logic        levelNeg = 1'b0;
  logic        pulseNeg = 1'b0;
  logic        clrInt1 = 1'b0;
  logic        clrInt2 = 1'b0;
  logic [23:0] samples = '0;
  logic [7:0]  threshold = 8'd40;
  logic [2:0]  singlePulse = '0;
  logic [2:0]  doublePulse = '0;
  logic        win2Zero = 1'b0;
  logic        int1Bit, int2Bit, int1Pin, int2Pin;
  logic [2:0]  levelSrc, pulseSrc;

  int vectors = 0;
  int fails = 0;
  string curReq = "R1";

  bit m1, m2;
  bit [2:0] mLvl, mPls;

  always #2 clk = ~clk;

  motion_irq_router dut (.*);

  task automatic setS(input int x, input int y, input int z);
    samples = {8'(z), 8'(y), 8'(x)};
  endtask

  task automatic quiet();
    clrInt1 = 0; clrInt2 = 0; singlePulse = '0; doublePulse = '0;
  endtask

  task automatic modelAdvance();
    int enCnt;
    bit [2:0] lvlM, sglM, dblM;
    bit lvlE, sglE, dblE;
    enCnt = 0; lvlM = 0; sglM = 0; dblM = 0;
    if (rst) begin
      m1 = 0; m2 = 0; mLvl = 0; mPls = 0;
      return;
    end
    for (int i = 0; i < 3; i++) begin
      int v, t, a;
      bit ok;
      if (axisDisable[i]) continue;
      enCnt++;
      v = $signed(samples[i*8 +: 8]);
      if (thrSigned) begin t = $signed(threshold); a = v; end
      else begin t = threshold; a = (v < 0) ? -v : v; end
      ok = (a >= t);
      if (levelNeg) ok = !ok;
      lvlM[i] = ok;
      sglM[i] = singlePulse[i];
      dblM[i] = doublePulse[i];
    end
    lvlE = levelNeg ? (enCnt > 0 && $countones(lvlM) == enCnt) : (lvlM != 0);
    sglE = pulseNeg ? (enCnt > 0 && $countones(sglM) == enCnt) : (sglM != 0);
    dblE = pulseNeg ? (enCnt > 0 && $countones(dblM) == enCnt) : (dblM != 0);
    case (modeSel)
      2'b00: begin
        if (clrInt1) begin m1 = 0; mLvl = 0; end
        if (clrInt2) begin m2 = 0; mPls = 0; end
        if (lvlE) begin m1 = 1; mLvl |= lvlM; end
        if (sglE) begin m2 = 1; mPls |= sglM; end
      end
      2'b01: begin
        if (clrInt1) begin m1 = 0; mPls = 0; end
        if (clrInt2) begin m2 = 0; mLvl = 0; end
        if (sglE) begin m1 = 1; mPls |= sglM; end
        if (lvlE) begin m2 = 1; mLvl |= lvlM; end
      end
      2'b10: begin
        if (clrInt2) begin m1 = 0; m2 = 0; mPls = 0; end
        if (sglE) begin m1 = 1; mPls |= sglM; if (win2Zero) m2 = 1; end
        if (!win2Zero && dblE) begin m2 = 1; mPls |= dblM; end
      end
      default: begin
        if (clrInt1) m1 = 0;
        if (clrInt2) m2 = 0;
      end
    endcase
  endtask

  task automatic step();
    logic [9:0] act, expv;
    modelAdvance();
    @(posedge clk);
    @(negedge clk);
    act  = {int1Bit, int2Bit, int1Pin, int2Pin, levelSrc, pulseSrc};
    expv = {m1, m2, pinSwap ? m2 : m1, pinSwap ? m1 : m2, mLvl, mPls};
    vectors++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: {i1,i2,p1,p2,lvl,pls} actual=%b expected=%b", curReq, act, expv);
    end
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    curReq = "R1"; rst = 1; setS(100, 100, 100); step(); step();
    rst = 0;
    // R2: level on X to INT1, single pulse on Y to INT2
    curReq = "R2"; step(); setS(0, 0, 0); step();
    setS(50, 0, 0); step(); setS(0, 0, 0);
    singlePulse = 3'b010; step(); quiet(); step();
    // R7: clears, clear-zero no effect, event beats clear
    curReq = "R7"; step();
    clrInt1 = 1; step(); quiet(); step();
    setS(0, -60, 0); clrInt1 = 1; step(); quiet(); setS(0, 0, 0); step();
    clrInt2 = 1; singlePulse = 3'b100; step(); quiet(); step();
    clrInt1 = 1; clrInt2 = 1; step(); quiet(); step();
    // R3: swapped routing
    curReq = "R3"; modeSel = 2'b01;
    setS(0, 0, 90); step(); setS(0, 0, 0); singlePulse = 3'b001; step(); quiet(); step();
    clrInt1 = 1; step(); quiet(); clrInt2 = 1; step(); quiet(); step();
    // R4: single/double route
    curReq = "R4"; modeSel = 2'b10; win2Zero = 0;
    singlePulse = 3'b001; step(); quiet(); step();
    doublePulse = 3'b100; step(); quiet(); step();
    curReq = "R8"; clrInt1 = 1; step(); quiet(); step();
    clrInt2 = 1; step(); quiet(); step();
    curReq = "R4"; win2Zero = 1; singlePulse = 3'b010; step(); quiet(); step();
    doublePulse = 3'b010; curReq = "R8"; clrInt2 = 1; step(); quiet(); step();
    clrInt2 = 1; singlePulse = 3'b001; step(); quiet(); clrInt2 = 1; step(); quiet();
    // R5: idle route
    curReq = "R5"; modeSel = 2'b11; setS(120, 120, 120);
    singlePulse = 3'b111; doublePulse = 3'b111; step(); quiet(); step(); setS(0, 0, 0);
    // R6: pin swap
    curReq = "R6"; modeSel = 2'b00; setS(60, 0, 0); step(); setS(0, 0, 0);
    pinSwap = 1; step(); step(); pinSwap = 0; step();
    clrInt1 = 1; step(); quiet();
    // R9: negative level polarity, AND of below-threshold axes
    curReq = "R9"; levelNeg = 1; setS(10, 10, 80); step();
    setS(10, -10, 39); step(); clrInt1 = 1; setS(50, 50, 50); step(); quiet();
    levelNeg = 0; setS(39, -39, 40); step(); clrInt1 = 1; setS(0, 0, 0); step(); quiet();
    // R10: pulse polarity
    curReq = "R10"; pulseNeg = 1; singlePulse = 3'b011; step(); quiet(); step();
    singlePulse = 3'b111; step(); quiet(); clrInt2 = 1; step(); quiet();
    // R11: disabled axes
    curReq = "R11"; axisDisable = 3'b100; singlePulse = 3'b011; step(); quiet();
    clrInt2 = 1; step(); quiet(); pulseNeg = 0;
    setS(0, 0, 100); singlePulse = 3'b100; step(); quiet();
    axisDisable = 3'b111; levelNeg = 1; setS(0, 0, 0); step(); levelNeg = 0;
    singlePulse = 3'b111; setS(99, 99, 99); step(); quiet(); setS(0, 0, 0);
    axisDisable = 3'b000; step();
    // R12: magnitude versus signed compare
    curReq = "R12"; setS(-100, 0, 0); step(); clrInt1 = 1; step(); quiet();
    thrSigned = 1; step(); threshold = 8'hF0; setS(-20, -16, -15); step();
    clrInt1 = 1; threshold = 8'd40; thrSigned = 0; setS(-128, 0, 0); step(); quiet();
    clrInt1 = 1; setS(0, 0, 0); step(); quiet(); step();
    // R13: random mix, flags checked every cycle
    curReq = "R13";
    for (int n = 0; n < 4000; n++) begin
      modeSel     = 2'($urandom_range(0, 3));
      pinSwap     = 1'($urandom_range(0, 1));
      axisDisable = ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'b000;
      thrSigned   = 1'($urandom_range(0, 1));
      levelNeg    = ($urandom_range(0, 3) == 0);
      pulseNeg    = ($urandom_range(0, 3) == 0);
      clrInt1     = ($urandom_range(0, 5) == 0);
      clrInt2     = ($urandom_range(0, 5) == 0);
      samples     = 24'($urandom);
      threshold   = ($urandom_range(0, 2) == 0) ? 8'($urandom) : 8'($urandom_range(60, 127));
      singlePulse = ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'b000;
      doublePulse = ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'b000;
      win2Zero    = 1'($urandom_range(0, 1));
      rst         = ($urandom_range(0, 499) == 0);
      step();
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule